// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a programmable device that sits downstream of it and takes its configuration over a passive serial link. A one-cycle start pulse, sampled together with a word count, opens a reset handshake. The block pulls the active-low request line down and waits for the device to drop its status line. It keeps the request low for a settling time, releases it, and then waits for status to come back high.

After the handshake, 16-bit words arrive over a valid/ready stream. The block shifts them out one bit per configuration clock pulse, lowest bit first. After every pulse it checks the device's done flag and its status line. Data transfer ends in one of three ways: done rises, status falls, or the word count runs out. A fixed train of trailing clock pulses then starts the device. Last, a 2-bit result code is latched.

The configuration clock comes from the system clock. Its high and low phases last a set number of system cycles each. Whenever the stream has no data, the configuration clock stays low, because the device sets no upper limit on the clock period.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset the outputs are as follows: cfg_req_n_o = 1, cfg_clk_o = 0, cfg_data_o = 0, busy_o = 0, done_o = 0 and s_ready_o = 0.
- R2: A start pulse drives cfg_req_n_o low. It stays low until dev_status_n_i has been seen low and a further NWAIT_CYC cycles have passed, and then returns high. No configuration clock edge occurs while the request is low, or while status has not yet come back high after release.
- R3: Data bits are sent least significant bit first within each word. cfg_data_o is stable while cfg_clk_o is high. Each high phase lasts at least HI_CYC system cycles and each low phase at least LO_CYC.
- R4: If dev_done_i is high after a pulse, shifting stops at once, even in the middle of a word, and no further words are accepted. If done is already high when data would start, no data pulse is sent at all.
- R5: If dev_status_n_i is low after a data pulse, shifting stops and the result becomes code 1.
- R6: If the word count is exhausted while dev_done_i is still low, the result becomes code 1. A count of zero gives code 1 with no data pulse.
- R7: Whenever data transfer ends, exactly TRAIL_PULSES (10 by default) further clock pulses follow before the block finishes.
- R8: If there was no earlier error, the result is 2 when dev_done_i is low after the trailing pulses and 0 when it is high. Code 1 from an earlier error takes priority over code 2.
- R9: While s_valid_i is low and the block is waiting for a word, cfg_clk_o stays low and produces no edge. The stall causes no error, and transfer resumes when data arrives.
- R10: A start pulse while busy_o is high is ignored. An accepted start clears done_o. At the finish, busy_o falls and done_o rises, and result_o is valid while done_o is high. Result encoding: 0 = success, 1 = error during transfer, 2 = not configured after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a configuration run |
| word_count_i | input | CNT_W | Number of stream words available, sampled with start |
| s_data_i | input | WORD_W | Configuration word |
| s_valid_i | input | 1 | Stream word is valid |
| s_ready_o | output | 1 | Block accepts the stream word this cycle |
| cfg_req_n_o | output | 1 | Active-low configuration request to the device |
| cfg_data_o | output | 1 | Serial configuration data |
| cfg_clk_o | output | 1 | Configuration clock |
| dev_status_n_i | input | 1 | Active-low device status |
| dev_done_i | input | 1 | Device reports configuration complete |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Run finished; result_o is valid |
| result_o | output | 2 | 0 success, 1 error during transfer, 2 not configured |

## Verification
A device model answers the handshake and raises done after a chosen pulse count. With this model, the stream is run in several patterns. A mid-word done shows that the early stop happens at bit granularity. A status drop after pulse 5 separates the code-1 path from a normal finish. A short word count and a zero count check exhaustion. A done that rises and then falls during the trailing pulses is the only way to produce code 2, and it shows that done is sampled after the trailer. Finally, a stall between words, a done level present before any data, and a start sent mid-run show that pausing, skipping data and ignoring a second start all leave the pulse count and the result as predicted.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_HOLD,
    ST_REL,
    ST_FETCH,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_TGO,
    ST_THIGH,
    ST_TLOW
  } cfg_state_e;

  typedef logic [1:0] cfg_res_t;

  localparam cfg_res_t RES_OK     = 2'd0;
  localparam cfg_res_t RES_XFER   = 2'd1;
  localparam cfg_res_t RES_NOCONF = 2'd2;

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R3: a running phase counts down one step per cycle
  a_r3_timer_step: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         adv_i,
  output logic         bit_o,
  output logic         last_o
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sreg_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      sreg_q <= word_i;
      idx_q  <= '0;
    end else if (adv_i) begin
      sreg_q <= sreg_q >> 1;
      idx_q  <= idx_q + IW'(1);
    end
  end

  assign bit_o  = sreg_q[0];
  assign last_o = (idx_q == IW'(W - 1));

  // R3: the controller never steps past the final bit of a word
  a_r3_no_adv_past_end: assert property (@(posedge clk) disable iff (rst)
    adv_i |-> !last_o);

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int CNT_W        = 16,
  parameter int HI_CYC       = 2,
  parameter int LO_CYC       = 3,
  parameter int NWAIT_CYC    = 4,
  parameter int TRAIL_PULSES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  word_count_i,
  input  logic [WORD_W-1:0] s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic              cfg_req_n_o,
  output logic              cfg_data_o,
  output logic              cfg_clk_o,
  input  logic              dev_status_n_i,
  input  logic              dev_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o
);

  localparam int TMAX0 = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int TMAX  = (TMAX0 > NWAIT_CYC) ? TMAX0 : NWAIT_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int TRW   = $clog2(TRAIL_PULSES + 1);

  cfg_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TRW-1:0]   trail_q, trail_d;
  logic             err_q, err_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  cfg_res_t         res_q, res_d;
  logic             req_q, req_d;
  logic             clk_q, clk_d;

  logic             tmr_load, tmr_exp;
  logic [TW-1:0]    tmr_val;
  logic             sh_load, sh_adv, sh_bit, sh_last;
  logic             ready;

  ps_cfg_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  ps_cfg_shifter #(.W(WORD_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load_i (sh_load),
    .word_i (s_data_i),
    .adv_i  (sh_adv),
    .bit_o  (sh_bit),
    .last_o (sh_last)
  );

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    trail_d  = trail_q;
    err_d    = err_q;
    busy_d   = busy_q;
    done_d   = done_q;
    res_d    = res_q;
    req_d    = req_q;
    clk_d    = clk_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_adv   = 1'b0;
    ready    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_REQ;
          cnt_d   = word_count_i;
          trail_d = '0;
          err_d   = 1'b0;
          busy_d  = 1'b1;
          done_d  = 1'b0;
          req_d   = 1'b0;
        end
      end
      ST_REQ: begin
        if (!dev_status_n_i) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(NWAIT_CYC - 1);
          st_d     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          req_d = 1'b1;
          st_d  = ST_REL;
        end
      end
      ST_REL: begin
        if (dev_status_n_i) st_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (dev_done_i) begin
          st_d = ST_TGO;
        end else if (cnt_q == '0) begin
          err_d = 1'b1;
          st_d  = ST_TGO;
        end else begin
          ready = 1'b1;
          if (s_valid_i) begin
            sh_load = 1'b1;
            cnt_d   = cnt_q - CNT_W'(1);
            st_d    = ST_SETUP;
          end
        end
      end
      ST_SETUP, ST_TGO: begin
        clk_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(HI_CYC - 1);
        st_d     = (st_q == ST_SETUP) ? ST_HIGH : ST_THIGH;
      end
      ST_HIGH, ST_THIGH: begin
        if (tmr_exp) begin
          clk_d    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TW'(LO_CYC - 1);
          st_d     = (st_q == ST_HIGH) ? ST_LOW : ST_TLOW;
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          if (dev_done_i) begin
            st_d = ST_TGO;
          end else if (!dev_status_n_i) begin
            err_d = 1'b1;
            st_d  = ST_TGO;
          end else if (sh_last) begin
            st_d = ST_FETCH;
          end else begin
            sh_adv = 1'b1;
            st_d   = ST_SETUP;
          end
        end
      end
      ST_TLOW: begin
        if (tmr_exp) begin
          if (trail_q == TRW'(TRAIL_PULSES - 1)) begin
            res_d  = err_q ? RES_XFER : (dev_done_i ? RES_OK : RES_NOCONF);
            busy_d = 1'b0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            trail_d = trail_q + TRW'(1);
            st_d    = ST_TGO;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      trail_q <= '0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      req_q   <= 1'b1;
      clk_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      trail_q <= trail_d;
      err_q   <= err_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      res_q   <= res_d;
      req_q   <= req_d;
      clk_q   <= clk_d;
    end
  end

  assign s_ready_o   = ready;
  assign cfg_req_n_o = req_q;
  assign cfg_data_o  = sh_bit;
  assign cfg_clk_o   = clk_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign result_o    = res_q;

  // high-phase length tracker used only by the width assertion
  logic [7:0] hi_len_q;
  always_ff @(posedge clk) begin
    if (rst)                              hi_len_q <= '0;
    else if (!clk_q)                      hi_len_q <= '0;
    else if (hi_len_q != 8'hFF)           hi_len_q <= hi_len_q + 8'd1;
  end

  // R3: data does not move while the configuration clock is high
  a_r3_data_stable: assert property (@(posedge clk) disable iff (rst)
    (cfg_clk_o && $past(cfg_clk_o)) |-> $stable(cfg_data_o));

  // R3: each high phase lasts at least HI_CYC cycles
  a_r3_high_width: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_clk_o) |-> ({1'b0, $past(hi_len_q)} + 9'd1 >= 9'(HI_CYC)));

  // R9: a word is only taken while the clock rests low
  a_r9_ready_clk_low: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> !cfg_clk_o);

  // R10: an idle block keeps the link quiet
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!cfg_clk_o && cfg_req_n_o));

  // R2: the request only drops in answer to an accepted start
  a_r2_req_from_start: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_req_n_o) |-> ($past(start_i) && !$past(busy_o)));

  // R7: a run only finishes after the full trailing train
  a_r7_trail_count: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> ($past(trail_q) == TRW'(TRAIL_PULSES - 1) && !busy_o));

endmodule

// File: tb/tb_ps_cfg_master.sv
module tb_ps_cfg_master;

  localparam int HI = 2;
  localparam int LO = 3;
  localparam int NW = 4;
  localparam int TR = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] wcount = '0;
  logic [15:0] s_data;
  logic        s_valid;
  logic        ready;
  logic        req_n, cdata, cclk;
  logic        status_n = 1'b1;
  logic        done_in = 1'b0;
  logic        busy, dn;
  logic [1:0]  res;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ps_cfg_master #(
    .WORD_W(16), .CNT_W(16), .HI_CYC(HI), .LO_CYC(LO),
    .NWAIT_CYC(NW), .TRAIL_PULSES(TR)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start), .word_count_i(wcount),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(ready),
    .cfg_req_n_o(req_n), .cfg_data_o(cdata), .cfg_clk_o(cclk),
    .dev_status_n_i(status_n), .dev_done_i(done_in),
    .busy_o(busy), .done_o(dn), .result_o(res)
  );

  function automatic logic [15:0] wval(int k);
    return 16'(((k + 1) * 40503) ^ 23130);
  endfunction

  // pulse capture
  int   pulses = 0;
  logic bits [0:1023];
  always @(posedge cclk) begin
    if (pulses < 1024) bits[pulses] = cdata;
    pulses++;
  end

  // word source
  int   widx = 0;
  int   base_w = 0;
  logic stall = 1'b0;
  assign s_valid = !stall;
  assign s_data  = wval(widx - base_w);
  always @(posedge clk) if (s_valid && ready) widx <= widx + 1;

  // device model and link monitors
  int   base_p = 0, done_at = 0, drop_at = 0, err_at = 0;
  bit   pre_done = 0;
  int   lowcnt = 0, relcnt = 100, hs_cnt = 0, hs_min = 1000;
  int   hi_run = 0, lo_run = 0, min_hi = 1000, min_lo = 1000;
  bit   had_pulse = 0, data_viol = 0, early_clk = 0;
  logic prev_clk = 1'b0, prev_data = 1'b0, prev_req = 1'b1;
  always @(negedge clk) begin
    int  rel;
    bit  in_err;
    rel    = pulses - base_p;
    in_err = (err_at != 0) && (rel >= err_at);
    if (!req_n) begin lowcnt++; relcnt = 0; end
    else begin lowcnt = 0; if (relcnt < 100) relcnt++; end
    status_n = !((!req_n && lowcnt >= 3) || (req_n && relcnt <= 2) || in_err);
    done_in  = pre_done || ((done_at != 0) && rel >= done_at &&
                            (drop_at == 0 || rel < drop_at));
    if (!req_n && !status_n) hs_cnt++;
    if (req_n && !prev_req) begin
      if (hs_cnt < hs_min) hs_min = hs_cnt;
      hs_cnt = 0;
    end
    if (cclk && (!req_n || (!status_n && !in_err))) early_clk = 1;
    if (cclk && prev_clk && cdata !== prev_data) data_viol = 1;
    if (cclk && !prev_clk) begin
      if (had_pulse && lo_run < min_lo) min_lo = lo_run;
      lo_run = 0;
      had_pulse = 1;
    end
    if (!cclk && prev_clk) begin
      if (hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
    end
    if (cclk) hi_run++; else lo_run++;
    prev_clk  = cclk;
    prev_data = cdata;
    prev_req  = req_n;
  end

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic kick(input int cnt, input int d_at, input int dr_at,
                      input int e_at, input bit pre);
    @(negedge clk);
    base_p   = pulses;
    base_w   = widx;
    done_at  = d_at;
    drop_at  = dr_at;
    err_at   = e_at;
    pre_done = pre;
    wcount   = 16'(cnt);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    chk(!dn && busy, "R10 start clears done and sets busy", int'({dn, busy}), 1);
  endtask

  task automatic wait_fin();
    while (!dn) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic verify(input int exp_p, input int exp_r, input int exp_w,
                        input int nbits, input string tag);
    bit bad = 0;
    int first = -1;
    chk(pulses - base_p == exp_p, {tag, " R7 total pulses"}, pulses - base_p, exp_p);
    chk(int'(res) == exp_r, {tag, " result code"}, int'(res), exp_r);
    chk(widx - base_w == exp_w, {tag, " R4 words taken"}, widx - base_w, exp_w);
    chk(!busy && dn, {tag, " R10 finish flags"}, int'({busy, dn}), 1);
    for (int i = 0; i < nbits; i++) begin
      logic [15:0] w;
      w = wval(i / 16);
      if (bits[base_p + i] !== w[i % 16]) begin
        if (!bad) first = i;
        bad = 1;
      end
    end
    chk(!bad, {tag, " R3 LSB-first bit stream (first bad bit index)"}, first, -1);
    done_at  = 0;
    drop_at  = 0;
    err_at   = 0;
    pre_done = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_n === 1'b1, "R1 request idle high", int'(req_n), 1);
    chk(cclk === 1'b0 && cdata === 1'b0, "R1 clock and data low", int'({cclk, cdata}), 0);
    chk(!busy && !dn && !ready, "R1 busy done ready low", int'({busy, dn, ready}), 0);
  endtask

  task automatic t_mid_word_done();
    kick(4, 40, 0, 0, 0);
    wait_fin();
    verify(40 + TR, 0, 3, 40, "R4 done mid word");
  endtask

  task automatic t_exhaust();
    kick(2, 0, 0, 0, 0);
    wait_fin();
    verify(32 + TR, 1, 2, 32, "R6 count exhausted");
  endtask

  task automatic t_zero_count();
    kick(0, 0, 0, 0, 0);
    wait_fin();
    verify(TR, 1, 0, 0, "R6 zero count");
  endtask

  task automatic t_status_err();
    kick(4, 0, 0, 5, 0);
    wait_fin();
    verify(5 + TR, 1, 1, 5, "R5 status drop");
  endtask

  task automatic t_noconf();
    kick(4, 20, 24, 0, 0);
    wait_fin();
    verify(20 + TR, 2, 2, 20, "R8 done lost in trailer");
  endtask

  task automatic t_pre_done();
    kick(4, 0, 0, 0, 1);
    wait_fin();
    verify(TR, 0, 0, 0, "R4 R8 done before data");
  endtask

  task automatic t_stall();
    int  p0;
    bit  edge_seen = 0;
    kick(4, 20, 0, 0, 0);
    while (pulses - base_p < 16) @(negedge clk);
    stall = 1'b1;
    p0 = pulses;
    repeat (10) @(negedge clk);
    p0 = pulses;
    repeat (40) @(negedge clk) if (cclk) edge_seen = 1;
    chk(pulses == p0 && !edge_seen, "R9 clock frozen during stall", pulses - p0, 0);
    chk(busy && !dn, "R9 stall is not an error", int'({busy, dn}), 2);
    stall = 1'b0;
    wait_fin();
    verify(20 + TR, 0, 2, 20, "R9 resume after stall");
  endtask

  task automatic t_restart_ignored();
    kick(4, 40, 0, 0, 0);
    while (pulses - base_p < 5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_n === 1'b1 && busy, "R10 second start ignored", int'({req_n, busy}), 3);
    wait_fin();
    verify(40 + TR, 0, 3, 40, "R10 run unaffected");
  endtask

  initial begin
    t_reset();
    t_mid_word_done();
    t_exhaust();
    t_zero_count();
    t_status_err();
    t_noconf();
    t_pre_done();
    t_stall();
    t_restart_ignored();
    chk(hs_min >= NW, "R2 request held low after status low", hs_min, NW);
    chk(!early_clk, "R2 no clock during handshake", int'(early_clk), 0);
    chk(min_hi >= HI, "R3 minimum high phase", min_hi, HI);
    chk(min_lo >= LO, "R3 minimum low phase", min_lo, LO);
    chk(!data_viol, "R3 data stable while clock high", int'(data_viol), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule